// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

This block is a single-clock FIFO controller wrapped around an internal storage array of `DEPTH` words of `DATA_W` bits. A master reset chooses between two read disciplines. In standard mode every word, including the first one after the FIFO was empty, must be pulled into the output register by a read request. In fall-through mode the oldest stored word moves onto the output by itself, and each read request consumes the word being shown.

Three flags report status. The flag polarity depends on the mode, so logic built for either convention can use the block directly. A partial reset empties the FIFO and keeps the mode. A retransmit request rewinds the read side to location zero, so everything written since the last reset can be sent again. During a fixed setup window after a retransmit request, reads and writes are ignored and the output flag reports that no data is ready.

Top module: `dual_mode_fifo`

## Requirements
- R1: On a clock edge with `mrst` high, `mode_sel` is latched: 0 selects standard mode and 1 selects fall-through mode. No other input changes the latched mode.
- R2: After any reset, `rd_data` is all zeros and `half_n` is 1. In standard mode `out_flag`=0 (empty) and `in_flag`=1 (not full). In fall-through mode `out_flag`=1 (no data ready) and `in_flag`=0 (space available).
- R3: Words leave in the order they were written. In standard mode, `rd_data` changes only on an edge with `rd_en`=1 while `out_flag`=1. A read and a write on the same edge are both performed.
- R4: In fall-through mode, the oldest stored word is loaded onto `rd_data` without a request on the second edge after it was written into an empty FIFO, and `out_flag` drops to 0. Each later word needs an edge with `rd_en`=1.
- R5: The FIFO holds at most `DEPTH` words, counting a word shown on the output in fall-through mode. It reports full as `in_flag`=0 in standard mode and `in_flag`=1 in fall-through mode. A write while full is ignored.
- R6: A read while no data is available leaves `rd_data` unchanged.
- R7: `half_n` is 0 exactly when the occupancy exceeds `DEPTH/2`, in both modes.
- R8: A retransmit setup starts when `rt_req`=1 on an edge with `wr_en`=0 and `rd_en`=0. Setup rewinds the read side to location zero, so the data written since the last reset (at most `DEPTH` words) is read out again. A retransmit request together with either enable has no effect.
- R9: Setup lasts `RT_CYCLES` edges, and reads and writes are ignored during it. In standard mode `out_flag` stays 0 until setup ends. In fall-through mode `out_flag` stays 1, and location zero is presented one edge after setup ends.
- R10: `prst` clears both pointers and the output register and keeps the latched mode. `mrst` takes priority over `prst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| mrst | input | 1 | Master reset, synchronous, active high; latches the mode |
| prst | input | 1 | Partial reset, synchronous, active high; keeps the mode |
| mode_sel | input | 1 | Mode choice sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Retransmit request |
| rd_data | output | DATA_W | Output register |
| out_flag | output | 1 | Standard: 1 = data available; fall-through: 0 = word valid on rd_data |
| in_flag | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| half_n | output | 1 | 0 when more than half full |

## Verification
The bench drives both modes through fill-to-full and drain-to-empty sweeps on a depth-8 instance. If the full test is off by one, a ninth word would be accepted or the eighth refused. If an empty read is not masked, `rd_data` would change to a stale array word. If the extra word held on the output is left out of the occupancy, `half_n` would switch one word late. Retransmit is tried together with each enable, which must have no effect, and then on its own. Writes and reads are attempted throughout setup, and the first replayed word must appear on the exact edge: one edge after setup ends in fall-through mode, and on request in standard mode. Mixed random traffic with partial resets follows, compared every cycle against a queue model.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dmf_mode_e;

    typedef struct packed {
        logic out_flag;
        logic in_flag;
        logic half_n;
    } dmf_flags_t;

    // Occupancy = words in storage plus the word held on the output.
    function automatic logic [15:0] occ_sum(input logic [15:0] mem_cnt, input logic held);
        return mem_cnt + {15'd0, held};
    endfunction

endpackage

// File: rtl/dmf_storage.sv
`timescale 1ns/1ps
module dmf_storage #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_rt_seq.sv
`timescale 1ns/1ps
module dmf_rt_seq #(
    parameter int RT_CYCLES = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic rt_req,
    input  logic rd_en,
    input  logic wr_en,
    output logic start,
    output logic busy
);
    localparam int CNTW = $clog2(RT_CYCLES + 1);
    localparam logic [CNTW-1:0] LOAD = CNTW'(RT_CYCLES);

    logic [CNTW-1:0] cnt;

    assign busy  = (cnt != '0);
    assign start = rt_req && !rd_en && !wr_en && !busy && !clr;

    always_ff @(posedge clk) begin
        if (clr)        cnt <= '0;
        else if (start) cnt <= LOAD;
        else if (busy)  cnt <= cnt - 1'b1;
    end

    // R8
    rt_start_chk: assert property (@(posedge clk) disable iff (clr)
        $rose(busy) |-> $past(rt_req && !rd_en && !wr_en));
endmodule

// File: rtl/dmf_flags.sv
`timescale 1ns/1ps
module dmf_flags
    import dmf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  dmf_mode_e    mode,
    input  logic [CW:0]  occ,
    input  logic         has_mem,
    input  logic         held,
    input  logic         busy,
    output dmf_flags_t   flags
);
    localparam logic [CW:0] FULL_OCC = (CW+1)'(DEPTH);
    localparam logic [CW:0] HALF_OCC = (CW+1)'(DEPTH / 2);

    logic is_full;
    assign is_full = (occ == FULL_OCC);

    always_comb begin
        if (mode == MODE_FWFT) begin
            flags.out_flag = !held;
            flags.in_flag  = is_full;
        end else begin
            flags.out_flag = has_mem && !busy;
            flags.in_flag  = !is_full;
        end
        flags.half_n = !(occ > HALF_OCC);
    end
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int DATA_W    = 18,
    parameter int DEPTH     = 64,
    parameter int RT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rt_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_flag,
    output logic              in_flag,
    output logic              half_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW:0] FULL_OCC = (CW+1)'(DEPTH);

    dmf_mode_e          mode_q;
    logic [CW-1:0]      wptr, rptr, mem_cnt;
    logic [CW:0]        occ;
    logic               held;
    logic               rst_any, has_mem, wr_ok, pop, drop;
    logic               rt_start, rt_busy;
    logic [DATA_W-1:0]  mem_rdata;
    dmf_flags_t         flags;

    assign rst_any = mrst || prst;
    assign mem_cnt = wptr - rptr;
    assign has_mem = (mem_cnt != '0);
    assign occ     = (CW+1)'(occ_sum(16'(mem_cnt), held));
    assign wr_ok   = wr_en && !rt_busy && (occ < FULL_OCC) && !rst_any;

    always_comb begin
        pop  = 1'b0;
        drop = 1'b0;
        if (!rt_busy) begin
            if (mode_q == MODE_FWFT) begin
                pop  = has_mem && (!held || rd_en);
                drop = !has_mem && rd_en && held;
            end else begin
                pop  = has_mem && rd_en;
            end
        end
    end

    dmf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) storage_i (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (rptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    dmf_rt_seq #(.RT_CYCLES(RT_CYCLES)) rt_seq_i (
        .clk    (clk),
        .clr    (rst_any),
        .rt_req (rt_req),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .start  (rt_start),
        .busy   (rt_busy)
    );

    dmf_flags #(.DEPTH(DEPTH)) flags_i (
        .mode    (mode_q),
        .occ     (occ),
        .has_mem (has_mem),
        .held    (held),
        .busy    (rt_busy),
        .flags   (flags)
    );

    always_ff @(posedge clk) begin
        if (rst_any) begin
            if (mrst) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
            wptr    <= '0;
            rptr    <= '0;
            held    <= 1'b0;
            rd_data <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rt_start) begin
                rptr <= '0;
                held <= 1'b0;
            end else if (pop) begin
                rptr    <= rptr + 1'b1;
                rd_data <= mem_rdata;
                held    <= (mode_q == MODE_FWFT);
            end else if (drop) begin
                held <= 1'b0;
            end
        end
    end

    assign out_flag = flags.out_flag;
    assign in_flag  = flags.in_flag;
    assign half_n   = flags.half_n;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst_any)
        occ <= FULL_OCC);

    // R6
    read_hold_chk: assert property (@(posedge clk) disable iff (rst_any)
        (mode_q == MODE_STD && !has_mem) |=> $stable(rd_data));

    // R8
    rt_rewind_chk: assert property (@(posedge clk) disable iff (rst_any)
        rt_start |=> (rptr == '0));

    // R3
    wptr_step_chk: assert property (@(posedge clk) disable iff (rst_any)
        (!$past(rst_any) && wptr != $past(wptr)) |-> (wptr == CW'($past(wptr) + 1'b1)));
endmodule

// File: tb/dual_mode_fifo_tb.sv
`timescale 1ns/1ps
module dual_mode_fifo_tb_top;
    localparam int DW  = 8;
    localparam int D   = 8;
    localparam int RTC = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic mrst = 1'b1, prst = 1'b0, mode_sel = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic out_flag, in_flag, half_n;

    dual_mode_fifo #(.DATA_W(DW), .DEPTH(D), .RT_CYCLES(RTC)) dut_i (
        .clk(clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt_req(rt_req),
        .rd_data(rd_data), .out_flag(out_flag), .in_flag(in_flag), .half_n(half_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] q[$];
    logic [DW-1:0] hist[$];
    logic [DW-1:0] m_out = '0;
    bit m_ov = 0;
    int m_bcnt = 0;
    bit m_fwft = 0;

    task automatic model_edge(bit mr, bit pr, bit ms, bit w, bit r, bit t, logic [DW-1:0] d);
        int total;
        bit busy, start, wok, popn, drop;
        if (mr || pr) begin
            if (mr) m_fwft = ms;
            q.delete(); hist.delete();
            m_out = '0; m_ov = 0; m_bcnt = 0;
            return;
        end
        total = q.size() + int'(m_ov);
        busy  = (m_bcnt != 0);
        start = t && !w && !r && !busy;
        wok   = w && !busy && (total < D);
        popn  = 0; drop = 0;
        if (!busy) begin
            if (!m_fwft) popn = r && (q.size() > 0);
            else begin
                popn = (q.size() > 0) && (!m_ov || r);
                drop = !popn && r && m_ov;
            end
        end
        if (!start) begin
            if (popn) begin m_out = q.pop_front(); m_ov = m_fwft; end
            else if (drop) m_ov = 0;
        end
        if (wok) begin q.push_back(d); hist.push_back(d); end
        if (start) begin m_bcnt = RTC; m_ov = 0; q = hist; end
        else if (busy) m_bcnt--;
    endtask

    task automatic compare(string tag);
        int total;
        logic e_of, e_if, e_hf;
        total = q.size() + int'(m_ov);
        if (m_fwft) begin e_of = !m_ov; e_if = (total == D); end
        else begin e_of = (q.size() != 0) && (m_bcnt == 0); e_if = (total != D); end
        e_hf = !(total > D/2);
        checks++;
        if ({rd_data, out_flag, in_flag, half_n} !== {m_out, e_of, e_if, e_hf}) begin
            fails++;
            $display("FAIL %s: got data=%h out=%b in=%b half=%b expected data=%h out=%b in=%b half=%b",
                     tag, rd_data, out_flag, in_flag, half_n, m_out, e_of, e_if, e_hf);
        end
    endtask

    task automatic cyc(bit mr, bit pr, bit ms, bit w, bit r, bit t, logic [DW-1:0] d, string tag);
        mrst = mr; prst = pr; mode_sel = ms; wr_en = w; rd_en = r; rt_req = t; wr_data = d;
        @(posedge clk);
        model_edge(mr, pr, ms, w, r, t, d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(logic [DW-1:0] d, string tag); cyc(0,0,0,1,0,0,d,tag); endtask
    task automatic rd(string tag);                   cyc(0,0,0,0,1,0,'0,tag); endtask
    task automatic idle(string tag);                 cyc(0,0,0,0,0,0,'0,tag); endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            cyc(1,0,m[0],0,0,0,'0,"R2");
            idle("R1");
            // fill past full: half-flag crossing, then ignored writes
            for (int i = 0; i < D + 2; i++)
                wr(DW'(8'h10 + i + m*64), (i < D) ? "R7" : "R5");
            idle("R5");
            // drain past empty
            for (int i = 0; i < D + 2; i++) rd((i < D) ? "R3" : "R6");
            idle("R6");
            // single word into an empty FIFO
            wr(8'hA5, "R4"); idle("R4"); idle("R4");
            rd("R4"); idle("R4");
            // simultaneous read and write
            for (int i = 0; i < 10; i++) cyc(0,0,0,1,1,0,DW'(8'h30 + i),"R3");
            // partial reset keeps mode
            cyc(0,1,~m[0],0,0,0,'0,"R10");
            idle("R10");
            cyc(1,1,m[0],0,0,0,'0,"R10");
            // retransmit
            for (int i = 0; i < 5; i++) wr(DW'(8'h50 + i), "R8");
            rd("R8"); rd("R8");
            cyc(0,0,0,1,0,1,8'h5F,"R8");
            cyc(0,0,0,0,1,1,'0,"R8");
            cyc(0,0,0,0,0,1,'0,"R8");
            for (int i = 0; i < RTC; i++) cyc(0,0,0,i[0],~i[0],0,8'hEE,"R9");
            idle("R9"); idle("R9");
            for (int i = 0; i < 9; i++) rd("R9");
            // mixed random traffic
            for (int i = 0; i < 400; i++) begin
                bit w, r, t, p;
                w = $urandom_range(0,1) == 1;
                r = $urandom_range(0,2) != 0;
                t = ($urandom_range(0,15) == 0) && (hist.size() <= D);
                p = ($urandom_range(0,79) == 0);
                cyc(0,p,0,w,r,t,DW'($urandom),"R3");
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule